// File: doc/BRIEF.md
# Flag Group Register Bank

This block holds a small set of independent condition-flag groups for a wide-word datapath. Each group is four bits: carry (C), most-significant (M), least-significant (L) and zero (Z). The datapath keeps several groups so that two interleaved computations can each keep their own condition state. The block does not compute flag values. It only decides which group changes, which bits of it change, and where the new bits come from.

Four sources can write a group. An arithmetic unit and a logic unit each replace the whole selected group, but only when the instruction-level flag-write enable is also high. A multiply-accumulate unit supplies new bits together with a per-bit mask, so it can change only some bits of the selected group. A control-register write reloads every group at once from one wide word. An instruction field selects the target group for the first three sources. The flags of that same group are presented combinationally for readback.

Top module: `flagbank`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every bit of every group.
- R2: A group's flags form a 4-bit vector with C in bit 0, M in bit 1, L in bit 2 and Z in bit 3. `sel_flags_o` shows the stored vector of the group indexed by `grp_sel` in the same cycle, with no clock edge in between.
- R3: When `alu_flag_en` and `arith_upd` are both high at a rising edge, the selected group becomes `arith_flags`.
- R4: When `alu_flag_en` and `logic_upd` are both high at a rising edge, the selected group becomes `logic_flags`.
- R5: While `alu_flag_en` is low, `arith_upd` and `logic_upd` have no effect on any group.
- R6: When `mac_upd` is high at a rising edge, each bit of the selected group whose `mac_mask` bit is 1 takes the matching `mac_flags` bit, and each bit whose mask bit is 0 keeps its value. An all-zero mask changes nothing.
- R7: When `csr_we` is high at a rising edge, every group g is loaded from `csr_wdata[4g+3:4g]`, whatever `grp_sel` is.
- R8: An arithmetic, logic or masked update leaves every group other than the selected one unchanged.
- R9: At most one of the gated arithmetic enable, the gated logic enable, `mac_upd` and `csr_we` is high in a cycle. In a cycle where none is high, all groups hold their values.
- R10: `grp_sel` is a 1-bit field with the default two groups: value 0 targets group 0 and value 1 targets group 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_sel | input | GSEL_W | Target and readback group index |
| alu_flag_en | input | 1 | Instruction-level flag-write enable for the arithmetic and logic sources |
| arith_upd | input | 1 | Arithmetic unit update request |
| arith_flags | input | 4 | Arithmetic unit flag vector |
| logic_upd | input | 1 | Logic unit update request |
| logic_flags | input | 4 | Logic unit flag vector |
| mac_upd | input | 1 | Multiply-accumulate masked update request |
| mac_flags | input | 4 | Multiply-accumulate flag vector |
| mac_mask | input | 4 | Per-bit write mask for the masked update |
| csr_we | input | 1 | Control-register write of all groups |
| csr_wdata | input | NUM_GROUPS*4 | Packed flag vectors for all groups |
| sel_flags_o | output | 4 | Flags of the group indexed by `grp_sel` |

## Verification
Some properties are checked on every cycle. The update sources must never overlap. A group that is not loaded must hold, and a loaded group must take its input data. A masked update must leave its masked-off bits alone and set its masked-on bits from the supplied vector. The arithmetic and logic requests must do nothing while the flag-write enable is low. A control-register write must land exactly in the full bank. Other behaviour only the directed scenarios can show: the reset value, the bit layout seen at the readback port, how a group is chosen by the select field, and the exact merged values produced by a chain of partial masks applied to known earlier contents.

// File: rtl/flagbank_pkg.sv
// Package: shared flag-group type and widths for the flag register bank.
// Assumes the bit order C (bit 0), M, L, Z (bit 3) in every flag vector.
package flagbank_pkg;

    localparam int FLAG_W = 4;

    typedef struct packed {
        logic z;
        logic l;
        logic m;
        logic c;
    } flag_grp_t;

endpackage

// File: rtl/flagbank_merge.sv
// Module: per-bit masked merge of a new flag vector over an old one.
// Assumes a mask bit of 1 selects the new bit and 0 keeps the old bit.
module flagbank_merge
    import flagbank_pkg::*;
(
    input  flag_grp_t old_flags,
    input  flag_grp_t new_flags,
    input  flag_grp_t mask,
    output flag_grp_t merged
);

    // Bitwise select between the old and the supplied value.
    always_comb begin
        merged = (old_flags & ~mask) | (new_flags & mask);
    end

endmodule

// File: rtl/flagbank_src_sel.sv
// Module: picks the single active update source and forms the next value
// for the selected group. Assumes the sources are mutually exclusive; a
// control-register write is handled by the caller and only blocks this path.
module flagbank_src_sel
    import flagbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      alu_flag_en,
    input  logic      arith_upd,
    input  flag_grp_t arith_flags,
    input  logic      logic_upd,
    input  flag_grp_t logic_flags,
    input  logic      mac_upd,
    input  flag_grp_t mac_flags,
    input  flag_grp_t mac_mask,
    input  logic      csr_we,
    input  flag_grp_t sel_old,
    output logic      grp_we,
    output flag_grp_t grp_d
);

    logic      arith_go;
    logic      logic_go;
    flag_grp_t mac_merged;

    // Gate the arithmetic and logic requests with the instruction enable.
    always_comb begin
        arith_go = alu_flag_en & arith_upd;
        logic_go = alu_flag_en & logic_upd;
    end

    flagbank_merge u_merge (
        .old_flags (sel_old),
        .new_flags (mac_flags),
        .mask      (mac_mask),
        .merged    (mac_merged)
    );

    // Choose the write data and enable for the selected group.
    always_comb begin
        grp_we = 1'b0;
        grp_d  = sel_old;
        if (arith_go) begin
            grp_we = 1'b1;
            grp_d  = arith_flags;
        end else if (logic_go) begin
            grp_we = 1'b1;
            grp_d  = logic_flags;
        end else if (mac_upd) begin
            grp_we = 1'b1;
            grp_d  = mac_merged;
        end
    end

    // R9: the update sources never overlap.
    p_one_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arith_go, logic_go, mac_upd, csr_we}));

endmodule

// File: rtl/flagbank_group_reg.sv
// Module: storage for one flag group with a load enable.
// Assumes a synchronous active-low reset that clears the group.
module flagbank_group_reg
    import flagbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ld,
    input  flag_grp_t d,
    output flag_grp_t q
);

    // Hold, load or clear the group on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

    // R8: a group that is not loaded keeps its value.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));

    // R3: a load takes the presented data at the next edge.
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d)));

endmodule

// File: rtl/flagbank.sv
// Module: bank of independent C/M/L/Z flag groups. The arithmetic, logic and
// masked sources write the group picked by grp_sel, and a control-register write
// reloads all groups. Assumes at most one source is active per cycle.
module flagbank
    import flagbank_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    localparam int GSEL_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int BANK_W    = NUM_GROUPS * FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GSEL_W-1:0] grp_sel,
    input  logic              alu_flag_en,
    input  logic              arith_upd,
    input  logic [FLAG_W-1:0] arith_flags,
    input  logic              logic_upd,
    input  logic [FLAG_W-1:0] logic_flags,
    input  logic              mac_upd,
    input  logic [FLAG_W-1:0] mac_flags,
    input  logic [FLAG_W-1:0] mac_mask,
    input  logic              csr_we,
    input  logic [BANK_W-1:0] csr_wdata,
    output logic [FLAG_W-1:0] sel_flags_o
);

    flag_grp_t         grp_q [NUM_GROUPS];
    flag_grp_t         sel_old;
    flag_grp_t         grp_d;
    logic              grp_we;
    logic [BANK_W-1:0] bank_flat;

    // Read the currently selected group for readback and merging.
    always_comb begin
        sel_old     = grp_q[grp_sel];
        sel_flags_o = sel_old;
    end

    flagbank_src_sel u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .alu_flag_en (alu_flag_en),
        .arith_upd   (arith_upd),
        .arith_flags (arith_flags),
        .logic_upd   (logic_upd),
        .logic_flags (logic_flags),
        .mac_upd     (mac_upd),
        .mac_flags   (mac_flags),
        .mac_mask    (mac_mask),
        .csr_we      (csr_we),
        .sel_old     (sel_old),
        .grp_we      (grp_we),
        .grp_d       (grp_d)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic      ld;
        flag_grp_t d;

        // Route either the control-register slice or the selected-group data.
        always_comb begin
            ld = csr_we | (grp_we & (grp_sel == GSEL_W'(g)));
            d  = csr_we ? flag_grp_t'(csr_wdata[g*FLAG_W +: FLAG_W]) : grp_d;
        end

        flagbank_group_reg u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (ld),
            .d     (d),
            .q     (grp_q[g])
        );

        assign bank_flat[g*FLAG_W +: FLAG_W] = grp_q[g];
    end

    // R6: masked-off bits of the target group are untouched.
    p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mac_upd |=> (((grp_q[$past(grp_sel)] ^ $past(sel_flags_o)) & ~$past(mac_mask)) == '0));

    // R6: masked-on bits of the target group take the supplied bits.
    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mac_upd |=> (((grp_q[$past(grp_sel)] ^ $past(mac_flags)) & $past(mac_mask)) == '0));

    // R5: with the flag enable low and no other source, nothing changes.
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_flag_en && !mac_upd && !csr_we) |=> $stable(bank_flat));

    // R7: a control-register write lands in the whole bank.
    p_csr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> (bank_flat == $past(csr_wdata)));

endmodule

// File: tb/sim_flagbank.sv
// Directed bench for the flag register bank.
module sim_flagbank;

    localparam int NG = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [0:0]     grp_sel;
    logic           alu_flag_en;
    logic           arith_upd;
    logic [3:0]     arith_flags;
    logic           logic_upd;
    logic [3:0]     logic_flags;
    logic           mac_upd;
    logic [3:0]     mac_flags;
    logic [3:0]     mac_mask;
    logic           csr_we;
    logic [NG*4-1:0] csr_wdata;
    logic [3:0]     sel_flags_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] model [NG];

    always #2.5 clk = ~clk;

    flagbank #(.NUM_GROUPS(NG)) u0 (
        .clk(clk), .rst_n(rst_n), .grp_sel(grp_sel),
        .alu_flag_en(alu_flag_en),
        .arith_upd(arith_upd), .arith_flags(arith_flags),
        .logic_upd(logic_upd), .logic_flags(logic_flags),
        .mac_upd(mac_upd), .mac_flags(mac_flags), .mac_mask(mac_mask),
        .csr_we(csr_we), .csr_wdata(csr_wdata),
        .sel_flags_o(sel_flags_o)
    );

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        alu_flag_en = 1'b0; arith_upd = 1'b0; logic_upd = 1'b0;
        mac_upd = 1'b0; csr_we = 1'b0;
        arith_flags = '0; logic_flags = '0; mac_flags = '0; mac_mask = '0;
        csr_wdata = '0;
    endtask

    // One clock with the inputs already driven, then back to idle.
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    // Check both groups against the model through the readback port.
    task automatic check_all(input string req);
        for (int g = 0; g < NG; g++) begin
            grp_sel = 1'(g);
            #0.5;
            chk(req, sel_flags_o, model[g]);
        end
    endtask

    task automatic t_reset();
        for (int g = 0; g < NG; g++) model[g] = 4'h0;
        check_all("R1");
    endtask

    task automatic t_arith();
        grp_sel = 1'b1; alu_flag_en = 1'b1; arith_upd = 1'b1; arith_flags = 4'b1011;
        step();
        model[1] = 4'b1011;
        check_all("R3/R8");
    endtask

    task automatic t_logic();
        grp_sel = 1'b0; alu_flag_en = 1'b1; logic_upd = 1'b1; logic_flags = 4'b0110;
        step();
        model[0] = 4'b0110;
        check_all("R4/R8");
    endtask

    task automatic t_gate();
        grp_sel = 1'b0; arith_upd = 1'b1; arith_flags = 4'b1111;
        step();
        check_all("R5 arith");
        grp_sel = 1'b1; logic_upd = 1'b1; logic_flags = 4'b0000;
        step();
        check_all("R5 logic");
    endtask

    task automatic t_mask(input logic [0:0] g, input logic [3:0] f, input logic [3:0] m);
        grp_sel = g; mac_upd = 1'b1; mac_flags = f; mac_mask = m;
        step();
        model[g] = (model[g] & ~m) | (f & m);
        check_all("R6/R8");
    endtask

    task automatic t_csr(input logic [NG*4-1:0] w);
        grp_sel = 1'b0; csr_we = 1'b1; csr_wdata = w;
        step();
        for (int g = 0; g < NG; g++) model[g] = w[g*4 +: 4];
        check_all("R7");
    endtask

    task automatic t_idle();
        repeat (3) step();
        check_all("R9");
    endtask

    // Readback follows grp_sel with no clock in between; bit 0 is C.
    task automatic t_select();
        grp_sel = 1'b0; #0.5; chk("R10 grp0", sel_flags_o, model[0]);
        grp_sel = 1'b1; #0.5; chk("R10 grp1", sel_flags_o, model[1]);
        chk("R2 C bit", {3'b000, sel_flags_o[0]}, {3'b000, model[1][0]});
        chk("R2 Z bit", {3'b000, sel_flags_o[3]}, {3'b000, model[1][3]});
    endtask

    initial begin
        idle_inputs();
        grp_sel = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_arith();
        t_logic();
        t_gate();
        t_mask(1'b1, 4'b0000, 4'b0101);
        t_mask(1'b1, 4'b0101, 4'b1010);
        t_mask(1'b0, 4'b1111, 4'b0000);
        t_mask(1'b0, 4'b1001, 4'b1001);
        t_csr(8'hA5);
        t_select();
        t_idle();
        t_csr(8'h3C);
        t_mask(1'b0, 4'b0011, 4'b0110);
        t_idle();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        t_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule